// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block collects three interrupt sources for a small 8-bit processor core and shows them in one 8-bit control/status register. The sources are an external pin whose active edge is programmable, a one-cycle overflow pulse from an 8-bit timer, and any change on a 4-bit group of input port pins. Each source has a sticky flag. Only software clears a flag, by writing the register.

Each flag is gated by its own enable bit. The gated flags are combined with a global enable to form the interrupt request to the core. The wake-up output is different: it is asserted while the core sleeps and any enabled flag is set, and it ignores the global enable. The core therefore always wakes, and the global enable only decides whether the vector is taken.

The external pin and the port pins each pass through a two-flop synchroniser before edge or change detection. A port change is a mismatch between the synchronised pins and a copy of them taken on the most recent port read.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset the control register reads 0x00, the edge-select bit (bit 6 of the option register) reads 1, and both irqReq and wakeUp are 0.
- R2: When the edge-select bit is 1, a rising edge on extPin sets the external flag (control bit 1) within four clock cycles. A falling edge does not set it.
- R3: When the edge-select bit is 0, a falling edge on extPin sets the external flag (control bit 1). A rising edge does not set it.
- R4: A one-cycle high pulse on tmrOverflow sets the timer flag (control bit 2) at the next clock edge.
- R5: If the synchronised portPins differ from the copy taken at the last portRdStb pulse, the port-change flag (control bit 0) is set. The flag keeps setting again after it is cleared until a port read makes the copy match. Once the copy matches and the flag is cleared, steady pins leave it at 0.
- R6: Flags are sticky. Hardware never clears them. A control register write (regWrEn=1, regSel=0) loads regWrData into every bit except bit 6, so writing 0 clears a flag and writing 1 sets it.
- R7: If a hardware set and a software clear reach the same flag in the same cycle, the flag ends up 1.
- R8: The irqReq output is 1 exactly when the global enable (bit 7) is 1 and at least one pair of flag and enable is set. The pairs are bit 0 with bit 3, bit 1 with bit 4, and bit 2 with bit 5. irqReq follows the register state with no added delay.
- R9: The wakeUp output is 1 exactly when sleeping is 1 and at least one of the same flag/enable pairs is set, whatever the global enable.
- R10: With regSel=0, regRdData returns the control register and bit 6 always reads 0. With regSel=1, it returns the edge-select bit at bit 6 and zeros elsewhere. An option write (regSel=1) takes bit 6 of regWrData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extPin | input | 1 | External interrupt pin, asynchronous |
| portPins | input | 4 | Monitored port pins, asynchronous |
| portRdStb | input | 1 | Port read strobe; takes the comparison copy |
| tmrOverflow | input | 1 | One-cycle timer rollover pulse |
| sleeping | input | 1 | Core is in sleep |
| regSel | input | 1 | 0 = control register, 1 = option register |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational |
| irqReq | output | 1 | Interrupt request to the core |
| wakeUp | output | 1 | Wake-up request while sleeping |

## Verification
The bench aims at three cases. The first is a timer pulse that arrives in the same cycle as a software clear; a design where the clear wins would lose the event. The second is an edge of the wrong polarity for the current edge select; a design with the polarity inverted, or one that triggers on both edges, would set the external flag on it. The third is a pin mismatch that persists across a clear; a design that compares against the previous sample, and not against the copy from the last port read, would leave the flag at 0. Random writes of the whole register with random sleep states compare irqReq and wakeUp against their gating rules, which catches a wake-up wrongly tied to the global enable.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W   = 8;
  localparam int PORT_W  = 4;
  localparam int NUM_SRC = 3;

  // source index order: port change, external pin, timer
  localparam int SRC_PORT = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_TMR  = 2;

  localparam int FLAG_BIT [NUM_SRC] = '{0, 1, 2};
  localparam int EN_BIT   [NUM_SRC] = '{3, 4, 5};
  localparam int GIE_BIT  = 7;
  localparam int EDGE_BIT = 6;

  typedef struct packed {
    logic [NUM_SRC-1:0] setSrc;
    logic               wrCtrl;
    logic               wrOpt;
  } irqStrobes_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portPins,
  input  logic              portRdStb,
  input  logic              tmrOverflow,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic              edgeRising,
  output irqStrobes_t       strobes
);
  logic              extSync;
  logic              extPrev;
  logic [PORT_W-1:0] portSync;
  logic [PORT_W-1:0] portCopy;
  logic              extHit;
  logic              portHit;

  irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_extSync (
    .clk(clk), .rstN(rstN), .d(extPin), .q(extSync)
  );

  irq_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_portSync (
    .clk(clk), .rstN(rstN), .d(portPins), .q(portSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extSync;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          portCopy <= '0;
    else if (portRdStb) portCopy <= portSync;

  always_comb begin
    if (edgeRising) extHit = extSync & ~extPrev;
    else            extHit = ~extSync & extPrev;
    portHit = |(portSync ^ portCopy);
  end

  always_comb begin
    strobes                  = '0;
    strobes.setSrc[SRC_PORT] = portHit;
    strobes.setSrc[SRC_EXT]  = extHit;
    strobes.setSrc[SRC_TMR]  = tmrOverflow;
    strobes.wrCtrl           = regWrEn & ~regSel;
    strobes.wrOpt            = regWrEn & regSel;
  end
endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic             sleeping,
  output logic [REG_W-1:0] regRdData,
  output logic [REG_W-1:0] ctrlReg,
  output logic             edgeRising,
  output logic             irqReq,
  output logic             wakeUp
);
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;
  logic               gieQ;
  logic [NUM_SRC-1:0] pending;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) begin
        flagQ[s] <= 1'b0;
        enQ[s]   <= 1'b0;
      end else begin
        if (strobes.wrCtrl) begin
          enQ[s]   <= regWrData[EN_BIT[s]];
          flagQ[s] <= regWrData[FLAG_BIT[s]] | strobes.setSrc[s];
        end else if (strobes.setSrc[s]) begin
          flagQ[s] <= 1'b1;
        end
      end
    assign pending[s] = flagQ[s] & enQ[s];
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               gieQ <= 1'b0;
    else if (strobes.wrCtrl) gieQ <= regWrData[GIE_BIT];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              edgeRising <= 1'b1;
    else if (strobes.wrOpt) edgeRising <= regWrData[EDGE_BIT];

  always_comb begin
    ctrlReg = '0;
    ctrlReg[GIE_BIT] = gieQ;
    for (int s = 0; s < NUM_SRC; s++) begin
      ctrlReg[FLAG_BIT[s]] = flagQ[s];
      ctrlReg[EN_BIT[s]]   = enQ[s];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel) regRdData[EDGE_BIT] = edgeRising;
    else        regRdData = ctrlReg;
  end

  assign irqReq = gieQ & (|pending);
  assign wakeUp = sleeping & (|pending);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portPins,
  input  logic              portRdStb,
  input  logic              tmrOverflow,
  input  logic              sleeping,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqReq,
  output logic              wakeUp
);
  irqStrobes_t      strobes;
  logic             edgeRising;
  logic [REG_W-1:0] ctrlReg;

  irq_flag_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .portPins(portPins),
    .portRdStb(portRdStb), .tmrOverflow(tmrOverflow), .regSel(regSel),
    .regWrEn(regWrEn), .edgeRising(edgeRising), .strobes(strobes)
  );

  irq_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regSel(regSel),
    .regWrData(regWrData), .sleeping(sleeping), .regRdData(regRdData),
    .ctrlReg(ctrlReg), .edgeRising(edgeRising), .irqReq(irqReq),
    .wakeUp(wakeUp)
  );
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irqReq,
  input logic       wakeUp,
  input logic       sleeping,
  input logic       tmrOverflow,
  input logic       regWrEn,
  input logic       regSel,
  input logic [7:0] ctrlReg
);
  // R8
  req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ctrlReg[7]);

  // R9
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> sleeping);

  // R4
  tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrOverflow |=> ctrlReg[2]);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmrOverflow && regWrEn && !regSel) |=> ctrlReg[2]);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|ctrlReg[2:0]) && !(regWrEn && !regSel)) |=> ((ctrlReg[2:0] & $past(ctrlReg[2:0])) == $past(ctrlReg[2:0])));

  // R10
  bit6_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[6]);
endmodule

bind irq_flag_unit irq_flag_chk u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .wakeUp(wakeUp),
  .sleeping(sleeping), .tmrOverflow(tmrOverflow), .regWrEn(regWrEn),
  .regSel(regSel), .ctrlReg(ctrlReg)
);

// File: tb/irq_flag_unit_test.sv
module irq_flag_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extPin = 1'b0;
  logic [3:0] portPins = 4'h0;
  logic       portRdStb = 1'b0;
  logic       tmrOverflow = 1'b0;
  logic       sleeping = 1'b0;
  logic       regSel = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       irqReq;
  logic       wakeUp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_flag_unit uut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .portPins(portPins),
    .portRdStb(portRdStb), .tmrOverflow(tmrOverflow), .sleeping(sleeping),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq), .wakeUp(wakeUp)
  );

  function automatic logic expReq(logic [7:0] r);
    return r[7] & ((r[0] & r[3]) | (r[1] & r[4]) | (r[2] & r[5]));
  endfunction

  function automatic logic expWake(logic [7:0] r, logic slp);
    return slp & ((r[0] & r[3]) | (r[1] & r[4]) | (r[2] & r[5]));
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(logic sel, logic [7:0] data);
    regSel = sel; regWrEn = 1'b1; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 1'b0;
  endtask

  task automatic rdCtrl(output logic [7:0] v);
    regSel = 1'b0; #0.5 v = regRdData;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] r;
    void'($urandom(32'd12345));
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    rdCtrl(v); check("R1 ctrl reset", v, 8'h00);
    regSel = 1'b1; #0.5 check("R1 edge select reset", regRdData, 8'h40);
    regSel = 1'b0;
    check("R1 irqReq reset", {7'd0, irqReq}, 8'd0);
    check("R1 wakeUp reset", {7'd0, wakeUp}, 8'd0);

    // R2 rising edge selected
    extPin = 1'b1; cyc(4);
    rdCtrl(v); check("R2 rising sets ext flag", v & 8'h02, 8'h02);
    wrReg(1'b0, 8'h00);
    extPin = 1'b0; cyc(4);
    rdCtrl(v); check("R2 falling ignored", v & 8'h02, 8'h00);

    // R10 option write/read
    wrReg(1'b1, 8'hBF);
    regSel = 1'b1; #0.5 check("R10 option readback", regRdData, 8'h00);
    regSel = 1'b0;

    // R3 falling edge selected
    extPin = 1'b1; cyc(4);
    rdCtrl(v); check("R3 rising ignored", v & 8'h02, 8'h00);
    extPin = 1'b0; cyc(4);
    rdCtrl(v); check("R3 falling sets ext flag", v & 8'h02, 8'h02);
    wrReg(1'b0, 8'h00);

    // R4 timer pulse
    tmrOverflow = 1'b1; cyc(1); tmrOverflow = 1'b0;
    rdCtrl(v); check("R4 timer flag", v & 8'h04, 8'h04);

    // R6 sticky, then software clear
    cyc(10);
    rdCtrl(v); check("R6 flag still set", v & 8'h04, 8'h04);
    wrReg(1'b0, 8'h00);
    rdCtrl(v); check("R6 software clear", v, 8'h00);

    // R7 set wins over clear
    wrReg(1'b0, 8'h04);
    regSel = 1'b0; regWrEn = 1'b1; regWrData = 8'h00; tmrOverflow = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; tmrOverflow = 1'b0;
    rdCtrl(v); check("R7 set wins", v & 8'h04, 8'h04);
    wrReg(1'b0, 8'h00);

    // R5 port change against read copy
    portPins = 4'b0101; cyc(4);
    rdCtrl(v); check("R5 change sets flag", v & 8'h01, 8'h01);
    wrReg(1'b0, 8'h00); cyc(1);
    rdCtrl(v); check("R5 mismatch re-sets flag", v & 8'h01, 8'h01);
    portRdStb = 1'b1; cyc(1); portRdStb = 1'b0;
    wrReg(1'b0, 8'h00); cyc(5);
    rdCtrl(v); check("R5 matched copy stays clear", v & 8'h01, 8'h00);

    // R8 disabled source gives no request
    wrReg(1'b0, 8'h87);
    check("R8 flags without enables", {7'd0, irqReq}, 8'd0);

    // R9 wake without global enable, no request
    wrReg(1'b0, 8'h24); sleeping = 1'b1; #0.5;
    check("R9 wake with gie clear", {7'd0, wakeUp}, 8'd1);
    check("R8 no req with gie clear", {7'd0, irqReq}, 8'd0);
    sleeping = 1'b0;

    // R8 R9 R10 random register writes
    for (int k = 0; k < 200; k++) begin
      r = 8'($urandom);
      wrReg(1'b0, r);
      sleeping = 1'($urandom);
      rdCtrl(v);
      check("R10 random readback", v, r & 8'hBF);
      check("R8 random irqReq", {7'd0, irqReq}, {7'd0, expReq(r)});
      check("R9 random wakeUp", {7'd0, wakeUp}, {7'd0, expWake(r, sleeping)});
    end
    sleeping = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule